// File: doc/BRIEF.md
# Response FIFO Receive Sequencer

This block sits on the host side of a trusted-module register interface and empties a response after a command has finished running. It issues single register reads and writes on a simple request/acknowledge bus. Register select 0 is the status register of locality 0 and select 1 is the byte-wide data register. It waits for the module to signal that data is present. It then fetches data bytes in groups whose size the status register advertises, and passes each byte on a valid/ready output stream. When the group is finished it checks the status again.

The number of bytes to collect starts at the configured buffer limit `BUF_BYTES`. Once the sixth byte has arrived, that number is replaced by the total length carried big-endian in header bytes 2 through 5, after the value has been checked against the header size and the limit. A successful drain ends with a command-ready write to the status register, which hands the FIFO back to the module. Every run, whether it succeeds or fails, ends with a one-cycle `done` pulse that carries the byte count and a result code. Status polls are bounded by `POLL_LIMIT`, so a silent or stalled module produces an error rather than a hang.

Top module: `tis_rx_sequencer`

## Requirements
- R1: After reset, `bus_req`, `out_valid` and `done` are low, and the block waits for a one-cycle `start`.
- R2: After `start`, the block reads status (select 0) until bit 4 (data available) and bit 7 (valid) are both 1. If `POLL_LIMIT` status reads in a row fail this test, the run ends with result code 1 and count 0.
- R3: The burst size is status bits 23:8. Between two status reads the block performs at most that many data reads (select 1). It stops early once the expected byte count has been reached.
- R4: Each data byte appears on `out_data` with `out_valid` high and is held stable until `out_ready` is sampled high. Bytes leave in the order they were read.
- R5: The expected count starts at `BUF_BYTES`. When the sixth byte is accepted, the count becomes the big-endian value (byte 2 most significant) formed from header bytes 2, 3, 4 and 5. A response whose length equals `BUF_BYTES` completes normally.
- R6: A decoded length below 6 or above `BUF_BYTES` ends the run with result code 2 and count 6. No further data reads are made.
- R7: If `POLL_LIMIT` consecutive status values with the valid and data-available bits set report a burst of zero, the run ends with result code 3.
- R8: After each group the block reads status until bit 7 is 1. It begins another group only while bits 4 and 7 are both 1 and the expected count has not been reached. If data runs out before the decoded length, the run ends normally with the shorter count.
- R9: If the last status value read still has bit 4 set, the run ends with result code 4 and no command-ready write is made.
- R10: On success the block writes 32'h40 to status (select 0), then ends with result code 0.
- R11: `done` is high for exactly one cycle per run. `rx_count` and `rx_err` are valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a receive run (accepted only when idle) |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = status register, 1 = data register |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes in a cycle where `bus_req` and `bus_ack` are both high |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| out_valid | output | 1 | Response byte available |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Downstream accepts the byte |
| done | output | 1 | One-cycle end-of-run pulse |
| rx_count | output | clog2(BUF_BYTES+1) | Bytes delivered in the run |
| rx_err | output | 3 | 0 ok, 1 wait timeout, 2 bad size, 3 stuck burst, 4 not drained |

## Verification
A corrupted byte counter or expected-length register appears at the ports within one group. Data reads continue past the advertised burst, `rx_count` disagrees with the header, or the release write is missing or unexpected. A header decoder that captures the wrong bytes changes the run's end immediately after the sixth byte: a bad-size result appears where success was due, or the other way round. A poll counter off by one shows as a status-read total that differs from `POLL_LIMIT` on the timeout and stuck paths. A stream-handshake fault shows up at the first stalled `out_ready`, as a byte that is lost or repeated.

// File: rtl/tis_rx_pkg.sv
package tis_rx_pkg;

    typedef enum logic [2:0] {
        RX_OK           = 3'd0,
        RX_WAIT_TIMEOUT = 3'd1,
        RX_BAD_SIZE     = 3'd2,
        RX_STUCK        = 3'd3,
        RX_NOT_DRAINED  = 3'd4
    } rx_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_DATA,
        S_BURST_CHK,
        S_STUCK_POLL,
        S_GROUP,
        S_RD_REQ,
        S_PUSH,
        S_WAIT_VALID,
        S_EXIT_CHK,
        S_RELEASE
    } rx_state_e;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    localparam int          STS_VALID_BIT = 7;
    localparam int          STS_AVAIL_BIT = 4;
    localparam logic [31:0] STS_CMD_READY = 32'h0000_0040;
    localparam int          HDR_BYTES     = 6;
    localparam int          HDR_LEN_FIRST = 2;

    function automatic logic [15:0] burst_of(input logic [31:0] sts);
        return sts[23:8];
    endfunction

    function automatic logic has_data(input logic [31:0] sts);
        return sts[STS_VALID_BIT] && sts[STS_AVAIL_BIT];
    endfunction

endpackage

// File: rtl/tis_poll_timer.sv
module tis_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    assign last = (cnt == W'(LIMIT - 1));

    // The owner stops ticking on the last poll, so the count never passes it.
    assert_poll_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(LIMIT - 1));

endmodule

// File: rtl/tis_len_decode.sv
module tis_len_decode
    import tis_rx_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic [31:0]      length,
    output logic             bad
);
    logic [23:0] hdr;

    // Header bytes 2..4 shift in; byte 5 completes the word combinationally.
    always_ff @(posedge clk) begin
        if (rst || clear)
            hdr <= '0;
        else if (push && idx >= CNT_W'(HDR_LEN_FIRST) && idx < CNT_W'(HDR_BYTES - 1))
            hdr <= {hdr[15:0], byte_in};
    end

    assign length = {hdr, byte_in};
    assign bad    = (length < 32'(HDR_BYTES)) || (length > 32'(BUF_BYTES));

endmodule

// File: rtl/tis_rx_sequencer.sv
module tis_rx_sequencer
    import tis_rx_pkg::*;
#(
    parameter int BUF_BYTES  = 64,
    parameter int POLL_LIMIT = 1000,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             bus_req,
    output logic             bus_wr,
    output logic             bus_sel,
    output logic [31:0]      bus_wdata,
    input  logic             bus_ack,
    input  logic [31:0]      bus_rdata,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             done,
    output logic [CNT_W-1:0] rx_count,
    output logic [2:0]       rx_err
);
    rx_state_e        state;
    logic [31:0]      sts_q;
    logic [15:0]      burst_left;
    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] expected;
    logic [7:0]       byte_q;
    logic             done_q;
    rx_err_e          err_q;

    logic        xfer, in_wait, wait_match, wait_last, stuck_last;
    logic        wait_clear, wait_tick, stuck_clear, stuck_tick;
    logic        hdr_push, len_bad;
    logic [31:0] len_word;
    logic [15:0] cur_burst;

    // Bus request decode
    always_comb begin
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
        bus_sel   = SEL_STATUS;
        bus_wdata = '0;
        unique case (state)
            S_WAIT_DATA, S_STUCK_POLL, S_WAIT_VALID: bus_req = 1'b1;
            S_RD_REQ: begin
                bus_req = 1'b1;
                bus_sel = SEL_DATA;
            end
            S_RELEASE: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_wdata = STS_CMD_READY;
            end
            default: ;
        endcase
    end

    assign xfer       = bus_req && bus_ack;
    assign in_wait    = (state == S_WAIT_DATA) || (state == S_WAIT_VALID);
    assign wait_match = (state == S_WAIT_DATA) ? has_data(bus_rdata)
                                               : bus_rdata[STS_VALID_BIT];
    assign wait_clear = (state == S_IDLE && start) || (xfer && in_wait && wait_match);
    assign wait_tick  = xfer && in_wait && !wait_match && !wait_last;

    assign cur_burst   = burst_of(sts_q);
    assign stuck_clear = (state == S_IDLE && start) ||
                         (state == S_BURST_CHK && cur_burst != '0);
    assign stuck_tick  = (state == S_BURST_CHK) && (cur_burst == '0) && !stuck_last;

    assign out_valid = (state == S_PUSH);
    assign out_data  = byte_q;
    assign hdr_push  = out_valid && out_ready;

    tis_poll_timer #(.LIMIT(POLL_LIMIT)) u_wait_timer (
        .clk(clk), .rst(rst), .clear(wait_clear), .tick(wait_tick), .last(wait_last)
    );

    tis_poll_timer #(.LIMIT(POLL_LIMIT)) u_stuck_timer (
        .clk(clk), .rst(rst), .clear(stuck_clear), .tick(stuck_tick), .last(stuck_last)
    );

    tis_len_decode #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_len (
        .clk(clk), .rst(rst), .clear(state == S_IDLE), .push(hdr_push),
        .idx(offset), .byte_in(byte_q), .length(len_word), .bad(len_bad)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            sts_q      <= '0;
            burst_left <= '0;
            offset     <= '0;
            expected   <= CNT_W'(BUF_BYTES);
            byte_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= RX_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    offset   <= '0;
                    expected <= CNT_W'(BUF_BYTES);
                    state    <= S_WAIT_DATA;
                end
                S_WAIT_DATA: if (xfer) begin
                    if (wait_match) begin
                        sts_q <= bus_rdata;
                        state <= S_BURST_CHK;
                    end else if (wait_last) begin
                        done_q <= 1'b1; err_q <= RX_WAIT_TIMEOUT; state <= S_IDLE;
                    end
                end
                S_BURST_CHK: begin
                    if (cur_burst == '0) begin
                        if (stuck_last) begin
                            done_q <= 1'b1; err_q <= RX_STUCK; state <= S_IDLE;
                        end else begin
                            state <= S_STUCK_POLL;
                        end
                    end else begin
                        burst_left <= cur_burst;
                        state      <= S_GROUP;
                    end
                end
                S_STUCK_POLL: if (xfer) begin
                    sts_q <= bus_rdata;
                    state <= S_BURST_CHK;
                end
                S_GROUP: begin
                    if (burst_left != '0 && offset < expected) state <= S_RD_REQ;
                    else                                       state <= S_WAIT_VALID;
                end
                S_RD_REQ: if (xfer) begin
                    byte_q <= bus_rdata[7:0];
                    state  <= S_PUSH;
                end
                S_PUSH: if (out_ready) begin
                    offset     <= offset + 1'b1;
                    burst_left <= burst_left - 1'b1;
                    state      <= S_GROUP;
                    if (offset == CNT_W'(HDR_BYTES - 1)) begin
                        if (len_bad) begin
                            done_q <= 1'b1; err_q <= RX_BAD_SIZE; state <= S_IDLE;
                        end else begin
                            expected <= len_word[CNT_W-1:0];
                        end
                    end
                end
                S_WAIT_VALID: if (xfer) begin
                    if (wait_match) begin
                        sts_q <= bus_rdata;
                        if (offset != expected && has_data(bus_rdata)) state <= S_BURST_CHK;
                        else                                           state <= S_EXIT_CHK;
                    end else if (wait_last) begin
                        done_q <= 1'b1; err_q <= RX_WAIT_TIMEOUT; state <= S_IDLE;
                    end
                end
                S_EXIT_CHK: begin
                    if (sts_q[STS_AVAIL_BIT]) begin
                        done_q <= 1'b1; err_q <= RX_NOT_DRAINED; state <= S_IDLE;
                    end else begin
                        state <= S_RELEASE;
                    end
                end
                S_RELEASE: if (xfer) begin
                    done_q <= 1'b1; err_q <= RX_OK; state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign rx_count = offset;
    assign rx_err   = err_q;

    // Assertions
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_stream_hold_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_sel) && $stable(bus_wr));

    assert_release_before_ok_R10: assert property (@(posedge clk) disable iff (rst)
        done && rx_err == 3'(RX_OK) |-> $past(bus_req && bus_ack && bus_wr));

    assert_bad_count_R6: assert property (@(posedge clk) disable iff (rst)
        done && rx_err == 3'(RX_BAD_SIZE) |-> rx_count == CNT_W'(HDR_BYTES));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(BUF_BYTES));

endmodule

// File: tb/tb_tis_rx_sequencer.sv
module tb_tis_rx_sequencer;
    localparam int BUF   = 64;
    localparam int POLLS = 20;
    localparam int CW    = $clog2(BUF + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bus_req, bus_wr, bus_sel, bus_ack;
    logic [31:0] bus_wdata, bus_rdata;
    logic out_valid, out_ready, done;
    logic [7:0] out_data;
    logic [CW-1:0] rx_count;
    logic [2:0] rx_err;

    always #5 clk = ~clk;

    tis_rx_sequencer #(.BUF_BYTES(BUF), .POLL_LIMIT(POLLS)) dut (
        .clk(clk), .rst(rst), .start(start),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done), .rx_count(rx_count), .rx_err(rx_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Module model configuration (written by the driver only)
    logic [7:0] mem [0:127];
    int fifo_n = 0, burst_cap = 1, stall_cfg = 0, zero_burst = 0, ready_mode = 0;

    // Model state (written by the model only)
    int rd_ptr = 0, stall_left = 0, last_burst = 0, since_sts = 0;
    int sts_reads = 0, cmd_writes = 0, burst_viol = 0;
    int tick = 0;

    always @(posedge clk) begin
        tick++;
        out_ready <= (ready_mode == 0) ? 1'b1 : ((tick % 3) != 0);
        bus_ack <= 1'b0;
        if (start) begin
            rd_ptr = 0;
            stall_left = stall_cfg;
        end
        if (!rst && bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_wr) begin
                if (!bus_sel && bus_wdata == 32'h40) cmd_writes++;
            end else if (bus_sel) begin
                bus_rdata <= {24'h0, (rd_ptr < 128) ? mem[rd_ptr] : 8'h00};
                rd_ptr++;
                since_sts++;
                if (since_sts > last_burst) burst_viol++;
            end else begin
                logic avail;
                int b;
                sts_reads++;
                avail = (rd_ptr < fifo_n) && (stall_left == 0);
                if (stall_left > 0) stall_left--;
                b = 0;
                if (avail && !zero_burst)
                    b = (fifo_n - rd_ptr < burst_cap) ? fifo_n - rd_ptr : burst_cap;
                bus_rdata <= {8'h00, b[15:0], 1'b1, 2'b00, avail, 4'h0};
                last_burst = b;
                since_sts = 0;
            end
        end
    end

    // Scoreboard
    byte unsigned exp_q[$];

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R4", "unexpected byte", int'(out_data), -1);
            end else begin
                check("R4", "stream byte", int'(out_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic run_case(string tag, int len_field, int fifo_len, int burst, int stall,
                            int zero, int rmode, int exp_err, int exp_cnt, int exp_cmd,
                            int exp_reads, int exp_ptr);
        int s0, c0, v0, guard;
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
        mem[0] = 8'h00; mem[1] = 8'hC4;
        mem[2] = 8'(len_field >> 24); mem[3] = 8'(len_field >> 16);
        mem[4] = 8'(len_field >> 8);  mem[5] = 8'(len_field);
        fifo_n = fifo_len; burst_cap = burst; stall_cfg = stall;
        zero_burst = zero; ready_mode = rmode;
        for (int i = 0; i < exp_cnt; i++) exp_q.push_back(mem[i]);
        s0 = sts_reads; c0 = cmd_writes; v0 = burst_viol;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        check("R11", {tag, " done seen"}, int'(done), 1);
        check("R11", {tag, " result code"}, int'(rx_err), exp_err);
        check("R11", {tag, " byte count"}, int'(rx_count), exp_cnt);
        @(negedge clk);
        check("R11", {tag, " done one cycle"}, int'(done), 0);
        check("R10", {tag, " command-ready writes"}, cmd_writes - c0, exp_cmd);
        check("R3", {tag, " burst overruns"}, burst_viol - v0, 0);
        check("R4", {tag, " bytes left in scoreboard"}, exp_q.size(), 0);
        if (exp_reads >= 0) check("R2", {tag, " status reads"}, sts_reads - s0, exp_reads);
        if (exp_ptr >= 0) check("R6", {tag, " data reads"}, rd_ptr, exp_ptr);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "bus_req after reset", int'(bus_req), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "done after reset", int'(done), 0);

        // R5 R3 R10: normal response, delayed data, bursts of 4
        run_case("R5 normal", 10, 10, 4, 3, 0, 0, 0, 10, 1, -1, 10);
        // R5: minimum length, burst 1, stalled stream (R4)
        run_case("R5 min", 6, 6, 1, 0, 0, 1, 0, 6, 1, -1, 6);
        // R6: length below header size
        run_case("R6 short", 5, 12, 4, 0, 0, 0, 2, 6, 0, -1, 6);
        // R6: length above limit
        run_case("R6 long", 65, 70, 8, 0, 0, 0, 2, 6, 0, -1, 6);
        // R5: length equal to limit, stalled stream
        run_case("R5 limit", 64, 64, 16, 2, 0, 1, 0, 64, 1, -1, 64);
        // R2: data never available
        run_case("R2 timeout", 10, 10, 4, 1000, 0, 0, 1, 0, 0, POLLS, 0);
        // R7: burst stuck at zero
        run_case("R7 stuck", 10, 10, 4, 0, 1, 0, 3, 0, 0, POLLS, 0);
        // R9: extra bytes left behind
        run_case("R9 undrained", 8, 12, 3, 0, 0, 0, 4, 8, 0, -1, 8);
        // R8: FIFO empties before the decoded length
        run_case("R8 short fifo", 10, 8, 4, 0, 0, 0, 0, 8, 1, -1, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule